// File: doc/BRIEF.md
# Programmable Frame Sync Pulse Generator

This block drives the frame synchronisation line of a framed serial port whose bit clock never stops, even while no data is moving. A timing source outside the block gives one strobe per bit slot, plus a marker on the strobe that opens each character, and states how many bits a character holds. From these the block decides which characters open a frame and shapes the frame sync level for each bit slot.

The interval between framed characters is a power of two, from 1 to 32 characters, selected by a 3-bit period code. The pulse lasts either one bit slot or one whole character. Its active level is either high or low. It starts either on the first bit slot of the framed character or one bit slot earlier. Turning framing on restarts the character count, so that the first character that begins afterwards is framed. A new period code is held back until the next framed character begins.

Top module: `frame_sync_gen`

## Requirements
- R1: With framing on, period code k (0 to 5) frames one character in every 2^k, counting the first character that starts after enable as framed. Codes 6 and 7 are reserved and must never be presented while framing is on.
- R2: While the enable input is 0, the output rests at its inactive level (the inverse of the polarity input) on every cycle, including directly after reset.
- R3: With the width select at 0, the pulse occupies exactly one bit slot.
- R4: With the width select at 1, the pulse occupies as many consecutive bit slots as the character width input gives (2 or more).
- R5: With the polarity input at 1 the active level is high; at 0 it is low.
- R6: With the alignment input at 1, the pulse begins on the bit slot that opens the framed character, that is, the slot whose strobe carries the character-start marker.
- R7: With the alignment input at 0, the pulse begins one bit slot before the framed character opens. For the first framed character after enable, this earlier pulse is produced only if that preceding slot also fell while framing was on.
- R8: Each time framing is switched on, the character count restarts, so the next character to start is framed whatever the count was before.
- R9: A period code written while framing is on is taken up when the next framed character opens. The interval that ends at that character still uses the old code.
- R10: The output level changes only on a clock edge where the bit-slot strobe is high, unless the enable or polarity input itself changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bit_tick | input | 1 | One-cycle strobe that opens each bit slot |
| char_first | input | 1 | Set together with bit_tick when that slot is the first bit of a character |
| char_bits | input | CBW (6) | Bits per character, 2 to MAX_BITS |
| fs_en | input | 1 | Framing enable |
| fs_wide | input | 1 | 1: pulse one character long, 0: one bit slot long |
| fs_pol | input | 1 | 1: active high, 0: active low |
| fs_coincide | input | 1 | 1: pulse on first bit of the framed character, 0: one slot earlier |
| period_code | input | 3 | Log2 of the number of characters between pulses (0 to 5) |
| fs_out | output | 1 | Frame synchronisation output |

## Verification
Assertions check, on every cycle, that a reserved period code never appears while framing is on. They also check that the character counter stays inside the latched period, that a coincident pulse only begins on a character-start strobe while an early one never does, that a narrow pulse ends after one slot, and that the output holds steady between strobes. Only the bench scenarios show the pulse rate for every period code, the exact slot span of wide and early pulses, the restart of the count after enable, and the deferred take-up of a new period code. In those scenarios every bit slot is compared against a frame schedule that the bench computes on its own.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int FSG_CODE_W   = 3;
  localparam int FSG_MAX_CODE = 5;
  localparam int FSG_CNT_W    = FSG_MAX_CODE;

  // All-ones mask of width code: the last character index of a period.
  function automatic logic [FSG_CNT_W-1:0] period_mask(input logic [FSG_CODE_W-1:0] code);
    logic [FSG_CNT_W:0] one_hot;
    one_hot = (FSG_CNT_W+1)'(1) << code;
    return FSG_CNT_W'(one_hot - (FSG_CNT_W+1)'(1));
  endfunction

endpackage

// File: rtl/fsg_slot_track.sv
module fsg_slot_track #(
  parameter int MAX_BITS = 32,
  parameter int BIDX_W   = $clog2(MAX_BITS),
  parameter int CBW      = $clog2(MAX_BITS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_tick,
  input  logic           char_first,
  input  logic [CBW-1:0] char_bits,
  output logic           slot_last_next
);

  logic [BIDX_W-1:0] bit_idx_q;
  logic [BIDX_W-1:0] bit_idx_d;
  logic [BIDX_W-1:0] idx_step;

  // Slot index that the current strobe opens.
  always_comb begin
    if (char_first) begin
      idx_step = '0;
    end else if (bit_idx_q == BIDX_W'(MAX_BITS - 1)) begin
      idx_step = bit_idx_q;
    end else begin
      idx_step = bit_idx_q + BIDX_W'(1);
    end
    bit_idx_d      = bit_tick ? idx_step : bit_idx_q;
    slot_last_next = (CBW'(idx_step) == (char_bits - CBW'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx_q <= '0;
    end else begin
      bit_idx_q <= bit_idx_d;
    end
  end

endmodule

// File: rtl/fsg_char_count.sv
module fsg_char_count
  import fsg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  bit_tick,
  input  logic                  char_first,
  input  logic [FSG_CODE_W-1:0] period_code,
  output logic                  last_before_frame,
  output logic                  frame_start
);

  logic [FSG_CNT_W-1:0]  cnt_q,  cnt_d;
  logic [FSG_CODE_W-1:0] code_q, code_d;
  logic [FSG_CNT_W-1:0]  mask_act;
  logic                  wrap;

  always_comb begin
    mask_act          = period_mask(code_q);
    wrap              = (cnt_q == mask_act);
    last_before_frame = en && wrap;
    frame_start       = en && bit_tick && char_first && wrap;
    cnt_d             = cnt_q;
    code_d            = code_q;
    if (!en) begin
      // Park on the last index so the next character opens a frame.
      code_d = period_code;
      cnt_d  = period_mask(period_code);
    end else if (bit_tick && char_first) begin
      if (wrap) begin
        cnt_d  = '0;
        code_d = period_code;
      end else begin
        cnt_d = cnt_q + FSG_CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (period_code <= FSG_CODE_W'(FSG_MAX_CODE))); // R1

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> (cnt_q <= period_mask(code_q))); // R9

endmodule

// File: rtl/fsg_pulse_shaper.sv
module fsg_pulse_shaper #(
  parameter int CBW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           bit_tick,
  input  logic           launch,
  input  logic           wide,
  input  logic [CBW-1:0] char_bits,
  output logic           active
);

  logic           act_q, act_d;
  logic [CBW-1:0] rem_q, rem_d;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    if (!en) begin
      act_d = 1'b0;
      rem_d = '0;
    end else if (bit_tick) begin
      if (launch) begin
        act_d = 1'b1;
        rem_d = wide ? (char_bits - CBW'(1)) : '0;
      end else if (act_q) begin
        if (rem_q == '0) begin
          act_d = 1'b0;
        end else begin
          rem_d = rem_q - CBW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end

  assign active = act_q;

  AST_NARROW_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_q && !wide && $past(!wide) && bit_tick && !launch) |=> !act_q); // R3

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int BIDX_W   = $clog2(MAX_BITS),
  parameter int CBW      = $clog2(MAX_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_tick,
  input  logic                  char_first,
  input  logic [CBW-1:0]        char_bits,
  input  logic                  fs_en,
  input  logic                  fs_wide,
  input  logic                  fs_pol,
  input  logic                  fs_coincide,
  input  logic [FSG_CODE_W-1:0] period_code,
  output logic                  fs_out
);

  logic slot_last_next;
  logic last_before_frame;
  logic frame_start;
  logic lead_launch;
  logic launch;
  logic active;

  fsg_slot_track #(
    .MAX_BITS (MAX_BITS),
    .BIDX_W   (BIDX_W),
    .CBW      (CBW)
  ) u_slot (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_tick       (bit_tick),
    .char_first     (char_first),
    .char_bits      (char_bits),
    .slot_last_next (slot_last_next)
  );

  fsg_char_count u_count (
    .clk               (clk),
    .rst_n             (rst_n),
    .en                (fs_en),
    .bit_tick          (bit_tick),
    .char_first        (char_first),
    .period_code       (period_code),
    .last_before_frame (last_before_frame),
    .frame_start       (frame_start)
  );

  always_comb begin
    lead_launch = fs_en && bit_tick && !char_first && slot_last_next && last_before_frame;
    launch      = fs_coincide ? frame_start : lead_launch;
  end

  fsg_pulse_shaper #(
    .CBW (CBW)
  ) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (fs_en),
    .bit_tick  (bit_tick),
    .launch    (launch),
    .wide      (fs_wide),
    .char_bits (char_bits),
    .active    (active)
  );

  assign fs_out = (fs_en && active) ? fs_pol : !fs_pol;

  AST_COINCIDE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(fs_coincide)) |-> ($past(bit_tick) && $past(char_first))); // R6

  AST_LEAD_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && !$past(fs_coincide)) |-> ($past(bit_tick) && !$past(char_first))); // R7

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && fs_en) |=> (!fs_en || !$stable(fs_pol) || $stable(fs_out))); // R10

endmodule

// File: tb/tb_frame_sync_gen.sv
module tb_frame_sync_gen;

  localparam int MAXB = 32;
  localparam int CBW  = $clog2(MAXB + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bit_tick;
  logic           char_first;
  logic [CBW-1:0] char_bits;
  logic           fs_en;
  logic           fs_wide;
  logic           fs_pol;
  logic           fs_coincide;
  logic [2:0]     period_code;
  logic           fs_out;

  int checks = 0;
  int fails  = 0;
  bit framed [0:299];

  always #10 clk = ~clk;

  frame_sync_gen #(.MAX_BITS(MAXB)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .char_first  (char_first),
    .char_bits   (char_bits),
    .fs_en       (fs_en),
    .fs_wide     (fs_wide),
    .fs_pol      (fs_pol),
    .fs_coincide (fs_coincide),
    .period_code (period_code),
    .fs_out      (fs_out)
  );

  task automatic chk(input logic got, input logic exp, input string rq, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%b exp=%b", rq, what, got, exp);
    end
  endtask

  // Bench-side frame schedule and slot expectation.
  function automatic bit slot_active(input int s, input int w, input int nch,
                                     input bit wide, input bit coin);
    int len;
    int off;
    len = wide ? w : 1;
    off = coin ? 0 : 1;
    for (int f = 0; f <= nch; f++) begin
      if (framed[f] && !(f == 0 && !coin)) begin
        if (s >= f*w - off && s <= f*w - off + len - 1) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic run_frames(input int code, input bit wide, input bit pol, input bit coin,
                            input int w, input int nch, input int chg_at, input int new_code,
                            input string rq);
    int nxt;
    int p;
    bit exp_act;
    fs_en = 1'b0;
    @(negedge clk);
    fs_wide = wide; fs_pol = pol; fs_coincide = coin;
    char_bits = CBW'(w); period_code = 3'(code);
    for (int c = 0; c < 300; c++) framed[c] = 1'b0;
    nxt = 0;
    for (int c = 0; c <= nch; c++) begin
      if (c == nxt) begin
        framed[c] = 1'b1;
        p = (c > chg_at) ? (1 << new_code) : (1 << code);
        nxt = c + p;
      end
    end
    @(negedge clk);
    fs_en = 1'b1;
    for (int c = 0; c < nch; c++) begin
      for (int b = 0; b < w; b++) begin
        @(negedge clk);
        bit_tick = 1'b1;
        char_first = (b == 0);
        if (c == chg_at && b == 1) period_code = 3'(new_code);
        @(negedge clk);
        bit_tick = 1'b0;
        char_first = 1'b0;
        exp_act = slot_active(c*w + b, w, nch, wide, coin);
        chk(fs_out, exp_act ? pol : !pol, rq, $sformatf("char %0d slot %0d", c, b));
        @(negedge clk);
        @(negedge clk);
        chk(fs_out, exp_act ? pol : !pol, "R10", $sformatf("hold char %0d slot %0d", c, b));
      end
    end
  endtask

  task automatic run_disabled(input bit pol, input int w, input int nch);
    fs_en = 1'b0;
    fs_pol = pol;
    fs_coincide = 1'b1;
    fs_wide = 1'b1;
    period_code = 3'd0;
    char_bits = CBW'(w);
    for (int c = 0; c < nch; c++) begin
      for (int b = 0; b < w; b++) begin
        @(negedge clk);
        bit_tick = 1'b1;
        char_first = (b == 0);
        @(negedge clk);
        bit_tick = 1'b0;
        char_first = 1'b0;
        chk(fs_out, !pol, "R2", $sformatf("disabled char %0d slot %0d", c, b));
      end
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    bit_tick = 1'b0; char_first = 1'b0; char_bits = CBW'(8);
    fs_en = 1'b0; fs_wide = 1'b0; fs_pol = 1'b1; fs_coincide = 1'b1; period_code = 3'd0;
    repeat (3) @(negedge clk);
    chk(fs_out, 1'b0, "R2", "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(fs_out, 1'b0, "R2", "after reset");
  endtask

  task automatic test_periods;
    for (int k = 0; k <= 5; k++)
      run_frames(k, 1'b0, 1'b1, 1'b1, 8, 2*(1 << k) + 1, 1000, 0, "R1");
    run_frames(2, 1'b0, 1'b1, 1'b1, 4, 9, 1000, 0, "R3");
    run_frames(1, 1'b0, 1'b1, 1'b1, 6, 5, 1000, 0, "R6");
  endtask

  task automatic test_width_pol;
    run_frames(2, 1'b1, 1'b0, 1'b1, 8, 9, 1000, 0, "R4");
    run_frames(1, 1'b0, 1'b0, 1'b1, 5, 5, 1000, 0, "R5");
    run_frames(0, 1'b1, 1'b1, 1'b1, 3, 4, 1000, 0, "R4");
  endtask

  task automatic test_lead;
    run_frames(1, 1'b0, 1'b1, 1'b0, 8, 7, 1000, 0, "R7");
    run_frames(0, 1'b1, 1'b1, 1'b0, 16, 3, 1000, 0, "R7");
    run_frames(2, 1'b1, 1'b0, 1'b0, 2, 9, 1000, 0, "R7");
  endtask

  task automatic test_restart;
    run_frames(3, 1'b0, 1'b1, 1'b1, 4, 3, 1000, 0, "R8");
    run_frames(3, 1'b0, 1'b1, 1'b1, 4, 10, 1000, 0, "R8");
  endtask

  task automatic test_code_change;
    run_frames(1, 1'b0, 1'b1, 1'b1, 4, 8, 1, 0, "R9");
    run_frames(0, 1'b0, 1'b1, 1'b1, 4, 13, 2, 3, "R9");
  endtask

  task automatic test_disable;
    run_disabled(1'b1, 4, 3);
    run_disabled(1'b0, 4, 3);
    run_frames(0, 1'b1, 1'b1, 1'b1, 4, 1, 1000, 0, "R4");
    @(negedge clk);
    fs_en = 1'b0;
    #1;
    chk(fs_out, 1'b0, "R2", "drop enable mid pulse");
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_periods();
        test_width_pol();
        test_lead();
        test_restart();
        test_code_change();
        test_disable();
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule